// File: doc/BRIEF.md
# Smooth Clock Calibration Pulse Masker

This block sits between a slow real-time oscillator clock and the prescaler chain that derives the one-second tick. Over a repeating calibration window it removes (masks) a programmed number of oscillator pulses. When the positive-correction bit is set it also inserts a fixed batch of extra counts. The prescaler therefore advances at a trimmed average rate. The net change per full-length window is `plus × 2^MASK_W − mask` prescaler counts. With the default sizes this is +512 down to −511 counts per 2^20 clocks (32 s at 32.768 kHz). One count is roughly 0.954 ppm, so the usable trim is about −487 ppm to +488 ppm.

Masked and inserted pulses are spread evenly across the window and are never bunched together. A masked pulse can occur only on a slot boundary, which comes every `2^(WIN_LOG2−MASK_W)` clocks. The slot index is bit-reversed and then compared against the mask count. An inserted count always falls half a slot away from the slot boundary. The window can be shortened to one half (16 s) or one quarter (8 s) of its full length. In those modes the low one or two mask bits are ignored and all per-window amounts scale down in proportion.

Writes to the calibration settings are allowed at any time without stopping the clock. A write is held in a shadow copy and raises a pending flag. The window boundary then moves the new values into use, restarts the window and clears the flag. A configuration-error output flags a nonzero calibration combined with an asynchronous prescaler value below 3. In that case the synchronous prescaler would have to be reduced.

Top module: `calib_masker`

## Requirements
- R1: After reset, `preInc` is 1 on every clock, `calPending` is 0 and `cfgErr` is 0; the active settings are plus=0, mask=0, full window.
- R2: A clock with `calWr`=1 captures `calPlus`, `calMask`, `calSel8` and `calSel16`. `calPending` is 1 from the next clock. The settings in use do not change while `calPending` is 1. At the end of the current window the captured settings take effect, `calPending` returns to 0 and a new window starts.
- R3: In the full window of 2^WIN_LOG2 clocks, the sum of `preInc` equals 2^WIN_LOG2 + plus×2^MASK_W − mask.
- R4: In the full window, exactly `mask` clocks have `preInc`=0; with mask=0 no clock has `preInc`=0.
- R5: With plus=1, exactly 2^MASK_W clocks per full window have `preInc`=2, one every 2^(WIN_LOG2−MASK_W) clocks; with plus=0 none do.
- R6: With `calSel16`=1 and `calSel8`=0, the window is 2^(WIN_LOG2−1) clocks. It contains mask>>1 masked clocks (mask bit 0 ignored) and plus×2^(MASK_W−1) inserted clocks.
- R7: With `calSel8`=1, the window is 2^(WIN_LOG2−2) clocks. It contains mask>>2 masked clocks and plus×2^(MASK_W−2) inserted clocks, whatever the value of `calSel16`.
- R8: Masked clocks are spread by bit-reversed slot order. With mask = 2^(MASK_W−1) in the full window, consecutive masked clocks are exactly 2×2^(WIN_LOG2−MASK_W) clocks apart.
- R9: `cfgErr` is 1 exactly when `asyncPsc` < 3 and the active settings are nonzero (plus=1 or mask≠0).
- R10: `preInc` only takes the values 0, 1 and 2; a masked clock and an inserted count never fall on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rstN | input | 1 | Active-low asynchronous reset |
| calWr | input | 1 | Write strobe for the calibration settings |
| calPlus | input | 1 | Insert 2^MASK_W counts per full window |
| calMask | input | MASK_W | Number of pulses to mask per full window |
| calSel16 | input | 1 | Select the half-length window |
| calSel8 | input | 1 | Select the quarter-length window (overrides calSel16) |
| asyncPsc | input | PSC_W | Current asynchronous prescaler setting |
| preInc | output | 2 | Prescaler counts to add this clock: 0 masked, 1 normal, 2 inserted |
| calPending | output | 1 | A written setting awaits the next window boundary |
| cfgErr | output | 1 | Calibration active with asynchronous prescaler below 3 |

## Verification
The assertions assume that `calWr` and the setting inputs are only sampled at the clock edge. They also assume that `asyncPsc` is a settled configuration value. A write may arrive at any time, including while a previous write is still pending. The stimulus changes the inputs only at falling edges. It measures each setting only after `calPending` has fallen, so every counted stretch lies wholly inside one stable configuration. Because the masking pattern repeats with the window length, the bench checks the per-window totals over any run of consecutive clocks of that length, without aligning to the window start.

// File: rtl/calib_pkg.sv
package calib_pkg;

  // Window length selection: full, half or quarter of 2^WIN_LOG2 clocks.
  // The encoding doubles as the right-shift applied to the window amounts.
  typedef enum logic [1:0] {
    WIN_FULL    = 2'd0,
    WIN_HALF    = 2'd1,
    WIN_QUARTER = 2'd2
  } winMode_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;  // latch new settings into the shadow copy
    logic apply;    // move shadow into active at the window boundary
  } calStrobe_t;

  function automatic winMode_t decodeMode(input logic sel8, input logic sel16);
    if (sel8)       return WIN_QUARTER;
    else if (sel16) return WIN_HALF;
    else            return WIN_FULL;
  endfunction

endpackage

// File: rtl/calib_ctrl.sv
module calib_ctrl
  import calib_pkg::*;
#(
  parameter int WIN_LOG2 = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                calWr,
  input  winMode_t            actMode,
  output logic [WIN_LOG2-1:0] winCnt,
  output calStrobe_t          strobe,
  output logic                calPending
);

  logic [1:0]          shAmt;
  logic [WIN_LOG2-1:0] lowMask;
  logic                winEnd;

  assign shAmt   = actMode;
  assign lowMask = {WIN_LOG2{1'b1}} >> shAmt;
  // last clock of the current window: all in-window counter bits set
  assign winEnd  = &(winCnt | ~lowMask);

  assign strobe.capture = calWr;
  assign strobe.apply   = winEnd & calPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt     <= '0;
      calPending <= 1'b0;
    end else begin
      winCnt <= strobe.apply ? '0 : winCnt + 1'b1;
      if (calWr)             calPending <= 1'b1;
      else if (strobe.apply) calPending <= 1'b0;
    end
  end

  // R2: a write raises the pending flag on the next clock
  p_pending_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    calWr |=> calPending);

  // R2: the flag only drops right after a window end
  p_pending_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(calPending) |-> $past(winEnd));

  // R2: the flag holds while inside a window
  p_pending_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (calPending && !winEnd) |=> calPending);

endmodule

// File: rtl/calib_dp.sv
module calib_dp
  import calib_pkg::*;
#(
  parameter int WIN_LOG2 = 20,
  parameter int MASK_W   = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  calStrobe_t          strobe,
  input  logic                calPlus,
  input  logic [MASK_W-1:0]   calMask,
  input  winMode_t            reqMode,
  input  logic [WIN_LOG2-1:0] winCnt,
  output winMode_t            actMode,
  output logic                actNonZero,
  output logic [1:0]          preInc
);

  localparam int SLOT_LOG2 = WIN_LOG2 - MASK_W;
  localparam logic [SLOT_LOG2-1:0] MID_PHASE = SLOT_LOG2'(1 << (SLOT_LOG2 - 1));

  // shadow and active settings
  logic              shPlus, actPlus;
  logic [MASK_W-1:0] shMask, actMask;
  winMode_t          shMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shPlus  <= 1'b0;
      shMask  <= '0;
      shMode  <= WIN_FULL;
      actPlus <= 1'b0;
      actMask <= '0;
      actMode <= WIN_FULL;
    end else begin
      if (strobe.capture) begin
        shPlus <= calPlus;
        shMask <= calMask;
        shMode <= reqMode;
      end
      if (strobe.apply) begin
        actPlus <= shPlus;
        actMask <= shMask;
        actMode <= shMode;
      end
    end
  end

  assign actNonZero = actPlus | (|actMask);

  // slot index within the window, bit-reversed for even spreading
  logic [1:0]        shAmt;
  logic [MASK_W-1:0] keep, slotIdx, revIdx, revScaled, maskScaled;
  logic              onSlot, midSlot, maskHit, insHit;

  assign shAmt   = actMode;
  assign keep    = {MASK_W{1'b1}} >> shAmt;
  assign slotIdx = winCnt[WIN_LOG2-1:SLOT_LOG2] & keep;

  for (genvar b = 0; b < MASK_W; b++) begin : g_rev
    assign revIdx[b] = slotIdx[MASK_W-1-b];
  end

  assign revScaled  = revIdx >> shAmt;
  assign maskScaled = actMask >> shAmt;
  assign onSlot     = (winCnt[SLOT_LOG2-1:0] == '0);
  assign midSlot    = (winCnt[SLOT_LOG2-1:0] == MID_PHASE);
  assign maskHit    = onSlot && (revScaled < maskScaled);
  assign insHit     = midSlot && actPlus;

  always_comb begin
    unique case ({maskHit, insHit})
      2'b10:   preInc = 2'd0;
      2'b01:   preInc = 2'd2;
      default: preInc = 2'd1;
    endcase
  end

  // R2: active settings only move on the apply strobe
  p_hold_act_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.apply |=> ($stable(actMask) && $stable(actPlus) && $stable(actMode)));

  // R4: no masking when the active mask count is zero
  p_no_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    (actMask == '0) |-> (preInc != 2'd0));

  // R5: an inserted count requires the plus setting
  p_ins_needs_plus_r5: assert property (@(posedge clk) disable iff (!rstN)
    (preInc == 2'd2) |-> actPlus);

endmodule

// File: rtl/calib_masker.sv
module calib_masker
  import calib_pkg::*;
#(
  parameter int WIN_LOG2 = 20,
  parameter int MASK_W   = 9,
  parameter int PSC_W    = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              calWr,
  input  logic              calPlus,
  input  logic [MASK_W-1:0] calMask,
  input  logic              calSel16,
  input  logic              calSel8,
  input  logic [PSC_W-1:0]  asyncPsc,
  output logic [1:0]        preInc,
  output logic              calPending,
  output logic              cfgErr
);

  logic [WIN_LOG2-1:0] winCnt;
  calStrobe_t          strobe;
  winMode_t            actMode, reqMode;
  logic                actNonZero;

  assign reqMode = decodeMode(calSel8, calSel16);

  calib_ctrl #(.WIN_LOG2(WIN_LOG2)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .calWr      (calWr),
    .actMode    (actMode),
    .winCnt     (winCnt),
    .strobe     (strobe),
    .calPending (calPending)
  );

  calib_dp #(.WIN_LOG2(WIN_LOG2), .MASK_W(MASK_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .calPlus    (calPlus),
    .calMask    (calMask),
    .reqMode    (reqMode),
    .winCnt     (winCnt),
    .actMode    (actMode),
    .actNonZero (actNonZero),
    .preInc     (preInc)
  );

  assign cfgErr = (asyncPsc < PSC_W'(3)) && actNonZero;

  // R9: a prescaler of 3 or more never raises the error
  p_err_psc_r9: assert property (@(posedge clk) disable iff (!rstN)
    (asyncPsc >= PSC_W'(3)) |-> !cfgErr);

  // R10: the increment never takes the value 3
  p_inc_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    preInc != 2'd3);

endmodule

// File: tb/tb_calib_masker.sv
module tb_calib_masker;

  localparam int WL   = 11;
  localparam int MW   = 9;
  localparam int PW   = 7;
  localparam int FULL = 1 << WL;
  localparam int SLOT = 1 << (WL - MW);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          calWr = 1'b0, calPlus = 1'b0, calSel16 = 1'b0, calSel8 = 1'b0;
  logic [MW-1:0] calMask = '0;
  logic [PW-1:0] asyncPsc = 7'd7;
  logic [1:0]    preInc;
  logic          calPending, cfgErr;

  always #4 clk = ~clk;  // 125 MHz

  calib_masker #(.WIN_LOG2(WL), .MASK_W(MW), .PSC_W(PW)) dut (
    .clk(clk), .rstN(rstN), .calWr(calWr), .calPlus(calPlus), .calMask(calMask),
    .calSel16(calSel16), .calSel8(calSel8), .asyncPsc(asyncPsc),
    .preInc(preInc), .calPending(calPending), .cfgErr(cfgErr)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  typedef struct {
    int    len;
    int    sum;
    int    masked;
    int    ins;
    string tag;
  } exp_t;

  exp_t q[$];
  bit   monBusy = 0;

  // monitor: counts over len consecutive falling-edge samples
  initial begin
    exp_t cur;
    int rem, sum, msk, ins, bad;
    forever begin
      @(negedge clk);
      if (monBusy) begin
        sum += int'(preInc);
        if (preInc == 2'd0) msk++;
        if (preInc == 2'd2) ins++;
        if (preInc == 2'd3) bad++;
        rem--;
        if (rem == 0) begin
          check(sum == cur.sum, {cur.tag, " sum"}, sum, cur.sum);
          check(msk == cur.masked, {cur.tag, " masked"}, msk, cur.masked);
          check(ins == cur.ins, {cur.tag, " inserted"}, ins, cur.ins);
          check(bad == 0, "R10 illegal increment", bad, 0);
          monBusy = 0;
        end
      end else if (q.size() > 0) begin
        cur = q.pop_front();
        rem = cur.len; sum = 0; msk = 0; ins = 0; bad = 0;
        monBusy = 1;
      end
    end
  end

  // driver: expected item computed from the requirements
  task automatic expectWindow(input bit plus, input int mask, input bit s8, input bit s16,
                              input string tag);
    exp_t e;
    int sh;
    sh = s8 ? 2 : (s16 ? 1 : 0);
    e.len    = FULL >> sh;
    e.masked = mask >> sh;
    e.ins    = plus ? ((1 << MW) >> sh) : 0;
    e.sum    = e.len - e.masked + e.ins;
    e.tag    = tag;
    #1 q.push_back(e);
  endtask

  task automatic drainMonitor();
    wait (q.size() == 0 && !monBusy);
    @(negedge clk);
  endtask

  // write settings and wait until they are in use
  task automatic writeCal(input bit plus, input int mask, input bit s8, input bit s16);
    int n;
    @(negedge clk);
    calWr = 1; calPlus = plus; calMask = MW'(mask); calSel8 = s8; calSel16 = s16;
    @(negedge clk);
    calWr = 0;
    check(calPending == 1'b1, "R2 pending set after write", calPending, 1);
    n = 0;
    while (calPending && n < 3 * FULL) begin
      @(negedge clk);
      n++;
    end
    check(n <= FULL, "R2 pending clears within one window", n, FULL);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int nonOne, n, last, badGap, cnt;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(preInc == 2'd1, "R1 reset preInc", preInc, 1);
    check(calPending == 1'b0, "R1 reset pending", calPending, 0);
    check(cfgErr == 1'b0, "R1 reset cfgErr", cfgErr, 0);
    rstN = 1;
    @(negedge clk);
    check(preInc == 2'd1, "R1 preInc after reset", preInc, 1);

    // R2: old settings (all zero) stay in use while pending
    @(negedge clk);
    calWr = 1; calPlus = 1; calMask = 9'd100; calSel8 = 0; calSel16 = 0;
    @(negedge clk);
    calWr = 0;
    check(calPending == 1'b1, "R2 pending set", calPending, 1);
    nonOne = 0; n = 0;
    while (calPending && n < 3 * FULL) begin
      if (preInc != 2'd1) nonOne++;
      @(negedge clk);
      n++;
    end
    check(nonOne == 0, "R2 old settings hold while pending", nonOne, 0);
    check(n <= FULL, "R2 pending clears at boundary", n, FULL);
    // R3: plus with partial mask
    expectWindow(1, 100, 0, 0, "R3 plus=1 mask=100");
    drainMonitor();

    // R4: maximum mask, no insertion
    writeCal(0, 511, 0, 0);
    expectWindow(0, 511, 0, 0, "R4 mask=511");
    drainMonitor();

    // R5: insertion only, spacing of inserted counts
    writeCal(1, 0, 0, 0);
    expectWindow(1, 0, 0, 0, "R5 plus=1 mask=0");
    last = -1; badGap = 0; cnt = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (preInc == 2'd2) begin
        if (last >= 0 && i - last != SLOT) badGap++;
        last = i; cnt++;
      end
    end
    check(badGap == 0, "R5 insertion spacing", badGap, 0);
    check(cnt == 256 / SLOT, "R5 insertion count in 256 clocks", cnt, 256 / SLOT);
    drainMonitor();

    // R8: half-scale mask spread every second slot
    writeCal(0, 256, 0, 0);
    expectWindow(0, 256, 0, 0, "R4 mask=256");
    last = -1; badGap = 0;
    for (int i = 0; i < FULL; i++) begin
      @(negedge clk);
      if (preInc == 2'd0) begin
        if (last >= 0 && i - last != 2 * SLOT) badGap++;
        last = i;
      end
    end
    check(badGap == 0, "R8 masked spacing", badGap, 0);
    drainMonitor();

    // R6: half window, mask bit 0 ignored
    writeCal(1, 5, 0, 1);
    expectWindow(1, 5, 0, 1, "R6 half window");
    drainMonitor();
    expectWindow(1, 5, 0, 1, "R6 half window repeat");
    drainMonitor();

    // R7: quarter window, low mask bits ignored; both selects set
    writeCal(0, 7, 1, 0);
    expectWindow(0, 7, 1, 0, "R7 quarter window");
    drainMonitor();
    writeCal(1, 7, 1, 1);
    expectWindow(1, 7, 1, 1, "R7 both selects");
    drainMonitor();

    // R10: full range, masking and insertion together
    writeCal(1, 511, 0, 0);
    expectWindow(1, 511, 0, 0, "R10 plus=1 mask=511");
    drainMonitor();

    // R9: configuration error
    asyncPsc = 7'd2;
    @(negedge clk);
    check(cfgErr == 1'b1, "R9 low prescaler with calibration", cfgErr, 1);
    asyncPsc = 7'd3;
    @(negedge clk);
    check(cfgErr == 1'b0, "R9 prescaler of 3", cfgErr, 0);
    writeCal(0, 0, 0, 0);
    asyncPsc = 7'd2;
    @(negedge clk);
    check(cfgErr == 1'b0, "R9 low prescaler with zero calibration", cfgErr, 0);
    check(preInc == 2'd1, "R4 zero settings give plain count", preInc, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule